// File: doc/BRIEF.md
# Misaligned Transfer Size Splitter

This block takes one operand access from a processor side (an address, an operand size of one, two or four bytes, a target port width of 8, 16 or 32 bits, and write data) and turns it into a series of aligned bus sub-transfers for an external bus controller. Each sub-transfer has its own address, a two-bit size code and the operand bytes it carries. A misaligned access is not rejected and is not forced into single bytes. It is cut into the largest aligned pieces that the address, the remaining byte count and the port width allow.

Both edges are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that cycle until the last sub-transfer of the request has been acknowledged. A sub-transfer is offered while `sub_valid` is high and moves on only on a cycle where `sub_ready` is also high. While the consumer holds `sub_ready` low, every `sub_*` output keeps its value, so the consumer can apply back-pressure for as long as it needs.

Top module: `xfer_splitter`

## Requirements
- R1: After reset, `req_ready` is high exactly when no sub-transfer is pending. An accepted request (size code not 11) raises `sub_valid` in the next cycle, and `req_ready` stays low while `sub_valid` is high.
- R2: `sub_size` is 01 for a one-byte piece, 10 for a two-byte piece and 00 for a four-byte piece. `req_size` uses the same codes for the operand.
- R3: Each piece is the largest of 4, 2 or 1 bytes that is no larger than the remaining byte count and the port width, and whose address is a multiple of its own size.
- R4: The first sub-transfer address equals `req_addr`. Each later address is the previous one plus the previous piece size.
- R5: A four-byte operand at address 0x1 on a 32-bit port produces three pieces: 01 at 0x1, 10 at 0x2, then 01 at 0x4.
- R6: `req_port` 01 selects an 8-bit port and 10 selects a 16-bit port, and no piece is wider than that port. 00 and 11 both select a 32-bit port.
- R7: `sub_data` holds the piece's operand bytes right-justified, with the earliest byte in the most significant position. Operand byte i (at address `req_addr`+i) is taken from `req_wdata` bits [8*(N-1-i)+7 : 8*(N-1-i)], where N is the operand size in bytes. Unused upper bits of `sub_data` are zero.
- R8: `sub_last` is high only on the final piece. In the cycle after that piece is acknowledged, `sub_valid` is low and `req_ready` is high.
- R9: While `sub_valid` is high and `sub_ready` is low, all `sub_*` outputs keep their values in the next cycle.
- R10: A request with size code 11 is accepted and produces no sub-transfer. `req_ready` stays high.
- R11: During and right after reset, `sub_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Operand size code (01 byte, 10 word, 00 longword) |
| req_port | input | 2 | Port width (01 8-bit, 10 16-bit, else 32-bit) |
| req_wdata | input | 32 | Operand value, right-justified |
| sub_valid | output | 1 | Sub-transfer offered |
| sub_ready | input | 1 | Sub-transfer acknowledged |
| sub_addr | output | ADDR_W | Sub-transfer address |
| sub_size | output | 2 | Sub-transfer size code |
| sub_data | output | 32 | Piece bytes, right-justified, big-endian |
| sub_last | output | 1 | Final piece of the request |

## Verification
A wrong remaining-byte count or a wrong address register shows up on the first acknowledged piece after the fault. The next `sub_addr`, `sub_size` or `sub_data` is then off in the very next cycle, or `sub_last` comes too early or too late. A bad busy flag shows up as `req_ready` and `sub_valid` being high together, or as a missing deassertion in the cycle after the final acknowledgement. Stalls inserted at random expose any piece that advances without `sub_ready`, because the stalled values no longer match the piece the bench still expects.

// File: rtl/xs_pkg.sv
package xs_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } sz_e;

  // number of bytes covered by a size code (line code gives 0)
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b01:   size_bytes = 3'd1;
      2'b10:   size_bytes = 3'd2;
      2'b00:   size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

  // port width code to bytes
  function automatic logic [2:0] port_bytes(input logic [1:0] code);
    case (code)
      2'b01:   port_bytes = 3'd1;
      2'b10:   port_bytes = 3'd2;
      default: port_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/xs_piece_pick.sv
module xs_piece_pick
  import xs_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [2:0] rem,
  input  logic [2:0] pbytes,
  output logic [2:0] nbytes,
  output logic [1:0] code
);
  logic fit4, fit2;

  always_comb begin
    fit4 = (rem >= 3'd4) && (pbytes >= 3'd4) && (addr_lo == 2'b00);
    fit2 = (rem >= 3'd2) && (pbytes >= 3'd2) && (addr_lo[0] == 1'b0);
    if (fit4) begin
      nbytes = 3'd4;
      code   = SZ_LONG;
    end else if (fit2) begin
      nbytes = 3'd2;
      code   = SZ_WORD;
    end else begin
      nbytes = 3'd1;
      code   = SZ_BYTE;
    end
  end
endmodule

// File: rtl/xs_lane_slice.sv
module xs_lane_slice #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [2:0]        rem,
  input  logic [2:0]        nbytes,
  output logic [DATA_W-1:0] data
);
  localparam int NB = DATA_W / 8;

  logic [2:0]        drop;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] mask;

  always_comb begin
    drop    = rem - nbytes;
    shifted = opnd >> {drop, 3'b000};
  end

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign mask[8*b +: 8] = (b < int'(nbytes)) ? 8'hFF : 8'h00;
  end

  assign data = shifted & mask;
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
  import xs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_port,
  input  logic [31:0]       req_wdata,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [1:0]        sub_size,
  output logic [31:0]       sub_data,
  output logic              sub_last
);
  localparam int DATA_W = 32;

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        rem_q;
  logic [2:0]        pbytes_q;
  logic [DATA_W-1:0] opnd_q;
  logic [2:0]        nbytes;
  logic [1:0]        code;
  logic              req_fire, sub_fire;

  assign req_ready = !busy_q;
  assign req_fire  = req_valid && req_ready;
  assign sub_fire  = busy_q && sub_ready;

  xs_piece_pick u_pick (
    .addr_lo (addr_q[1:0]),
    .rem     (rem_q),
    .pbytes  (pbytes_q),
    .nbytes  (nbytes),
    .code    (code)
  );

  xs_lane_slice #(.DATA_W(DATA_W)) u_slice (
    .opnd   (opnd_q),
    .rem    (rem_q),
    .nbytes (nbytes),
    .data   (sub_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
      pbytes_q <= 3'd4;
      opnd_q   <= '0;
    end else if (req_fire) begin
      busy_q   <= (req_size != SZ_LINE);
      addr_q   <= req_addr;
      rem_q    <= size_bytes(req_size);
      pbytes_q <= port_bytes(req_port);
      opnd_q   <= req_wdata;
    end else if (sub_fire) begin
      addr_q <= addr_q + ADDR_W'(nbytes);
      rem_q  <= rem_q - nbytes;
      if (nbytes == rem_q) busy_q <= 1'b0;
    end
  end

  assign sub_valid = busy_q;
  assign sub_addr  = addr_q;
  assign sub_size  = code;
  assign sub_last  = busy_q && (nbytes == rem_q);

  // ---------------- assertions ----------------
  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && sub_valid));

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size != 2'b11) |=> sub_valid);

  p_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_size == 2'b10) |-> (sub_addr[0] == 1'b0));

  p_long_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_size == 2'b00) |-> (sub_addr[1:0] == 2'b00));

  p_port_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_size == 2'b00) |-> (pbytes_q == 3'd4));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready) |=>
      (sub_valid && $stable(sub_addr) && $stable(sub_size) &&
       $stable(sub_data) && $stable(sub_last)));

  p_last_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_ready && sub_last) |=> (!sub_valid && req_ready));

  p_line_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == 2'b11) |=> !sub_valid);
endmodule

// File: tb/test_xfer_splitter.sv
module test_xfer_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_port = '0;
  logic [31:0] req_wdata = '0;
  logic        sub_valid;
  logic        sub_ready = 1'b0;
  logic [31:0] sub_addr;
  logic [1:0]  sub_size;
  logic [31:0] sub_data;
  logic        sub_last;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_splitter i_xfer_splitter (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_size,
    .req_port, .req_wdata, .sub_valid, .sub_ready, .sub_addr,
    .sub_size, .sub_data, .sub_last
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [1:0] sz);
    return (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : (sz == 2'b00) ? 4 : 0;
  endfunction

  function automatic int pb_of(input logic [1:0] pt);
    return (pt == 2'b01) ? 1 : (pt == 2'b10) ? 2 : 4;
  endfunction

  function automatic int pick(input logic [31:0] a, input int rem, input int pb);
    for (int k = 4; k >= 1; k = k / 2)
      if (k <= rem && k <= pb && (a % k) == 0) return k;
    return 1;
  endfunction

  function automatic logic [31:0] slice(input logic [31:0] d, input int nb,
                                        input int idx, input int k);
    logic [31:0] r = '0;
    for (int j = 0; j < k; j++)
      r = (r << 8) | ((d >> (8 * (nb - 1 - (idx + j)))) & 32'hFF);
    return r;
  endfunction

  task automatic run_req(input logic [31:0] a, input logic [1:0] sz,
                         input logic [1:0] pt, input logic [31:0] d,
                         input int stall_pct, input string tag);
    int nb, pb, rem, idx, k, guard;
    logic [31:0] cur;
    logic [1:0]  ecode;
    bit rdy;
    @(negedge clk);
    check(req_ready && !sub_valid, "R1", "idle before request", {30'd0, req_ready, sub_valid}, 32'h2);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_port = pt; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    nb = nb_of(sz); pb = pb_of(pt);
    if (nb == 0) begin
      check(!sub_valid && req_ready, "R10", "line size dropped", {30'd0, req_ready, sub_valid}, 32'h2);
      return;
    end
    rem = nb; idx = 0; cur = a; guard = 0;
    while (rem > 0 && guard < 200) begin
      guard++;
      k = pick(cur, rem, pb);
      ecode = (k == 4) ? 2'b00 : (k == 2) ? 2'b10 : 2'b01;
      check(sub_valid && !req_ready, {tag, " R1"}, "busy", {30'd0, req_ready, sub_valid}, 32'h1);
      check(sub_addr == cur, {tag, " R4"}, "address", sub_addr, cur);
      check(sub_size == ecode, {tag, " R2 R3 R6"}, "size code", {30'd0, sub_size}, {30'd0, ecode});
      check(sub_data == slice(d, nb, idx, k), {tag, " R7"}, "data", sub_data, slice(d, nb, idx, k));
      check(sub_last == (k == rem), {tag, " R8"}, "last flag", {31'd0, sub_last}, {31'd0, (k == rem)});
      rdy = ($urandom_range(99) >= stall_pct);
      sub_ready = rdy;
      @(negedge clk);
      if (rdy) begin
        cur = cur + k; idx += k; rem -= k;
      end else begin
        check(sub_valid && sub_addr == cur, {tag, " R9"}, "held under stall", sub_addr, cur);
      end
    end
    sub_ready = 1'b0;
    check(!sub_valid && req_ready, "R8", "idle after last", {30'd0, req_ready, sub_valid}, 32'h2);
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    check(!sub_valid && req_ready, "R11", "reset state", {30'd0, req_ready, sub_valid}, 32'h2);
    rst_n = 1'b1;
    // directed corners
    run_req(32'h0000_1001, 2'b00, 2'b00, 32'hA1B2C3D4, 0,  "R5");
    run_req(32'h0000_2000, 2'b00, 2'b00, 32'h11223344, 0,  "R3");
    run_req(32'h0000_3003, 2'b10, 2'b00, 32'h0000BEEF, 50, "R3");
    run_req(32'h0000_4002, 2'b00, 2'b01, 32'hCAFEF00D, 30, "R6");
    run_req(32'h0000_5000, 2'b00, 2'b10, 32'h01020304, 30, "R6");
    run_req(32'h0000_6003, 2'b00, 2'b00, 32'h55667788, 60, "R3");
    run_req(32'h0000_7000, 2'b11, 2'b00, 32'hFFFFFFFF, 0,  "R10");
    run_req(32'h0000_7001, 2'b01, 2'b10, 32'h000000AB, 0,  "R2");
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz = 2'($urandom_range(3));
      if ($urandom_range(9) == 0) sz = 2'b11; else if (sz == 2'b11) sz = 2'b00;
      run_req($urandom, sz, 2'($urandom_range(3)), $urandom, 40, "RND");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule